// File: doc/BRIEF.md
# Posted Store Buffer with Deferred Error Reporting

This block sits between the execute stage of a processor and its data bus and takes operand stores off the critical path. A store is accepted into a small first-in first-out buffer in a single cycle, and the instruction that issued it may retire at once. The buffer then hands its oldest entry to the bus. It removes that entry when the bus answers with either a completion or an error.

Because the write finishes after the store has left the pipeline, a bus error cannot be pinned on the instruction that caused it. It is reported late instead. The report carries the program counter that is current in the cycle the error arrives, not the program counter of the store. All architectural effects of the failing store are treated as already complete. A failing entry is dropped, reported once, and the entries behind it keep draining.

A synchronizing instruction holds itself in execute while the buffer still holds a write. Its program counter is therefore the current one when any pending error arrives, so that error is always reported against it.

Top module: `pwb_top`

## Requirements
- R1: After reset, `st_ready` is 1, and `bus_req`, `sync_stall` and `err_valid` are 0.
- R2: A store is taken on a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while DEPTH (4) entries are held. A store offered while `st_ready` is 0 is not taken and never reaches the bus.
- R3: `bus_req` is 1 whenever the buffer holds an entry. `bus_addr`, `bus_data` and `bus_size` show the oldest entry unchanged until `bus_ack` or `bus_err` removes it. Entries reach the bus in the order they were accepted, and the 2-bit size passes through unaltered.
- R4: When `bus_err` is 1 in a cycle where `bus_req` is 1, `err_valid` is 1 for exactly the next cycle. In that cycle `err_pc` equals the `cur_pc` seen in the error cycle.
- R5: An entry that ends in `bus_err` is discarded, and the next accepted entry is shown on the bus in the following cycle.
- R6: A write completed with `bus_ack` produces no error report.
- R7: `sync_stall` is 1 exactly when `sync_req` is 1 and the buffer holds an entry. It falls in the cycle after the last entry retires.
- R8: A write error that arrives while a sync instruction is stalled is reported with that sync instruction's program counter.
- R9: `bus_ack` and `bus_err` are ignored while `bus_req` is 0: no error report and no change to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by execute |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_size | input | 2 | Store size code |
| st_ready | output | 1 | Buffer can take a store this cycle |
| bus_req | output | 1 | Oldest entry is presented to the bus |
| bus_addr | output | 32 | Address of the presented write |
| bus_data | output | 32 | Data of the presented write |
| bus_size | output | 2 | Size code of the presented write |
| bus_ack | input | 1 | Presented write completed |
| bus_err | input | 1 | Presented write ended in error |
| sync_req | input | 1 | Synchronizing instruction is in execute |
| sync_stall | output | 1 | Hold the synchronizing instruction |
| cur_pc | input | 32 | Program counter of the instruction now in execute |
| err_valid | output | 1 | One-cycle write error report |
| err_pc | output | 32 | Program counter attached to the report |

## Verification
The tests use four kinds of input. In the first, the buffer is filled to its depth while the bus is held off, which separates correct full-stalling from overflow or the loss of an over-capacity store. Draining that buffer with completions only shows whether order and fields are kept and whether any report appears by mistake. In the second, an error falls in the middle of a run of stores. This tells a report tagged with the signalling-time program counter apart from one tagged with the store's own, and a discarded entry apart from a stalled queue. In the last, a sync instruction waits on a failing write, and separately, responses arrive on an idle bus. These show that the sync collects the error and that stray responses are ignored.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Advance a circular pointer, wrapping after the last slot.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of optional push and pop.
  function automatic int unsigned next_count(input int unsigned c, input logic push, input logic pop);
    return c + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int W     = 66,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         empty,
  output logic                         full
);
  import pwb_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      cnt <= CW'(next_count(int'(cnt), push, pop));
    end
  end
endmodule

// File: rtl/pwb_err_capture.sv
module pwb_err_capture #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fail,
  input  logic [PCW-1:0] cur_pc,
  output logic           err_valid,
  output logic [PCW-1:0] err_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_pc    <= '0;
    end else begin
      err_valid <= fail;
      if (fail) err_pc <= cur_pc;
    end
  end
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SW    = 2,
  parameter int PCW   = 32,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_valid,
  input  logic [AW-1:0]  st_addr,
  input  logic [DW-1:0]  st_data,
  input  logic [SW-1:0]  st_size,
  output logic           st_ready,
  output logic           bus_req,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_data,
  output logic [SW-1:0]  bus_size,
  input  logic           bus_ack,
  input  logic           bus_err,
  input  logic           sync_req,
  output logic           sync_stall,
  input  logic [PCW-1:0] cur_pc,
  output logic           err_valid,
  output logic [PCW-1:0] err_pc
);
  localparam int EW = AW + DW + SW;
  localparam int CW = $clog2(DEPTH+1);

  // Named internal events for the checker
  logic          push_evt, retire_evt, fail_evt, full_w, empty_w;
  logic [CW-1:0] fifo_cnt;
  logic [EW-1:0] head;

  assign st_ready   = !full_w;
  assign push_evt   = st_valid && st_ready;
  assign bus_req    = !empty_w;
  assign retire_evt = bus_req && (bus_ack || bus_err);
  assign fail_evt   = bus_req && bus_err;
  assign sync_stall = sync_req && !empty_w;
  assign {bus_addr, bus_data, bus_size} = head;

  pwb_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push_evt), .wdata({st_addr, st_data, st_size}),
    .pop(retire_evt), .rdata(head),
    .cnt(fifo_cnt), .empty(empty_w), .full(full_w)
  );

  pwb_err_capture #(.PCW(PCW)) u_err (
    .clk(clk), .rst_n(rst_n), .fail(fail_evt), .cur_pc(cur_pc),
    .err_valid(err_valid), .err_pc(err_pc)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SW    = 2,
  parameter int PCW   = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           st_valid,
  input logic           st_ready,
  input logic           bus_req,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_data,
  input logic [SW-1:0]  bus_size,
  input logic           bus_ack,
  input logic           bus_err,
  input logic           sync_req,
  input logic           sync_stall,
  input logic [PCW-1:0] cur_pc,
  input logic           err_valid,
  input logic [PCW-1:0] err_pc,
  input logic [CW-1:0]  fifo_cnt
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH)) |-> !st_ready);
  a_r3_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_size)));
  a_r4_err_report: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (err_valid && err_pc == $past(cur_pc)));
  a_r6_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_err) |=> !err_valid);
  a_r7_sync_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && bus_req) |-> sync_stall);
  a_r7_sync_free: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |-> !sync_stall);
  a_r9_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !st_valid) |=> (fifo_cnt == '0 && !err_valid));
endmodule

bind pwb_top pwb_checker #(
  .AW(AW), .DW(DW), .SW(SW), .PCW(PCW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
  .bus_ack(bus_ack), .bus_err(bus_err), .sync_req(sync_req), .sync_stall(sync_stall),
  .cur_pc(cur_pc), .err_valid(err_valid), .err_pc(err_pc), .fifo_cnt(fifo_cnt)
);

// File: tb/pwb_top_tb.sv
`timescale 1ns/1ps
module pwb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [1:0]  st_size = '0;
  logic        st_ready, bus_req, sync_stall, err_valid;
  logic [31:0] bus_addr, bus_data, err_pc;
  logic [1:0]  bus_size;
  logic        bus_ack = 1'b0, bus_err = 1'b0, sync_req = 1'b0;
  logic [31:0] cur_pc = 32'h1000;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwb_top u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_size(st_size), .st_ready(st_ready),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
    .bus_ack(bus_ack), .bus_err(bus_err), .sync_req(sync_req), .sync_stall(sync_stall),
    .cur_pc(cur_pc), .err_valid(err_valid), .err_pc(err_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance to the next falling edge, then let combinational outputs settle.
  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
    st_valid = 1'b1; st_addr = a; st_data = d; st_size = s;
    cyc();
    st_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 st_ready", 32'(st_ready), 32'd1);
    check("R1 bus_req", 32'(bus_req), 32'd0);
    check("R1 sync_stall", 32'(sync_stall), 32'd0);
    check("R1 err_valid", 32'(err_valid), 32'd0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 4; i++) begin
      check("R2 ready before push", 32'(st_ready), 32'd1);
      push(32'h100 + 32'(i*4), 32'hA0 + 32'(i), 2'(i));
    end
    check("R2 ready when full", 32'(st_ready), 32'd0);
    // Offer an extra store while full: it must not be taken.
    push(32'hDEAD, 32'hBEEF, 2'd3);
    for (int i = 0; i < 4; i++) begin
      check("R3 req", 32'(bus_req), 32'd1);
      check("R3 addr order", bus_addr, 32'h100 + 32'(i*4));
      check("R3 data", bus_data, 32'hA0 + 32'(i));
      check("R3 size", 32'(bus_size), 32'(i));
      bus_ack = 1'b1;
      cyc();
      bus_ack = 1'b0;
      check("R6 no report on ack", 32'(err_valid), 32'd0);
    end
    check("R2 extra store dropped", 32'(bus_req), 32'd0);
  endtask

  task automatic t_error_midstream();
    push(32'h200, 32'h1, 2'd2);
    push(32'h204, 32'h2, 2'd2);
    push(32'h208, 32'h3, 2'd2);
    cur_pc = 32'h3000;
    bus_ack = 1'b1; cyc(); bus_ack = 1'b0;
    cur_pc = 32'h3010;
    check("R5 second store on bus", bus_addr, 32'h204);
    bus_err = 1'b1; cyc(); bus_err = 1'b0;
    cur_pc = 32'h3020;
    check("R4 err_valid pulse", 32'(err_valid), 32'd1);
    check("R4 err_pc is signalling pc", err_pc, 32'h3010);
    check("R5 next entry continues", bus_addr, 32'h208);
    check("R5 req still up", 32'(bus_req), 32'd1);
    bus_ack = 1'b1; cyc(); bus_ack = 1'b0;
    check("R4 single report", 32'(err_valid), 32'd0);
    check("R5 buffer drained", 32'(bus_req), 32'd0);
  endtask

  task automatic t_sync();
    push(32'h300, 32'h11, 2'd1);
    push(32'h304, 32'h22, 2'd1);
    cur_pc = 32'h4444;
    sync_req = 1'b1; #1;
    check("R7 stall with entries", 32'(sync_stall), 32'd1);
    bus_ack = 1'b1; cyc(); bus_ack = 1'b0;
    check("R7 stall one entry left", 32'(sync_stall), 32'd1);
    bus_err = 1'b1; cyc(); bus_err = 1'b0;
    check("R7 stall released when empty", 32'(sync_stall), 32'd0);
    check("R8 error on sync", 32'(err_valid), 32'd1);
    check("R8 sync pc reported", err_pc, 32'h4444);
    sync_req = 1'b0;
    cyc();
    check("R7 no stall without sync", 32'(sync_stall), 32'd0);
  endtask

  task automatic t_idle_responses();
    cur_pc = 32'h5000;
    bus_err = 1'b1; bus_ack = 1'b1;
    cyc();
    bus_err = 1'b0; bus_ack = 1'b0;
    cyc();
    check("R9 no report from idle err", 32'(err_valid), 32'd0);
    check("R9 bus stays idle", 32'(bus_req), 32'd0);
    check("R9 ready unchanged", 32'(st_ready), 32'd1);
    push(32'h400, 32'h77, 2'd0);
    check("R9 queue not disturbed", bus_addr, 32'h400);
    bus_ack = 1'b1; cyc(); bus_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_fill_drain();
    t_error_midstream();
    t_sync();
    t_idle_responses();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule